// File: doc/BRIEF.md
# Flash Segment Window Decoder

This block keeps one window register per flash chip select. Each register holds two 8-bit fields, a start and an end, both counted in 8 MB units of the bus address. Together they place that device's segment inside the controller's fixed flash address range. Writes to a register are checked before they land. The check pins the first device's start to the range base, drops writes that fall outside the range, and raises sticky flags for segments that are misaligned or that overlap another one.

A combinational lookup port takes a bus address and returns three things: whether it falls in a non-empty segment, which chip select owns it, and the byte offset inside that segment. The flash access path uses these to pick a device and to form the device-side address. The error flags are cleared by writing ones to a clear mask.

Top module: `flash_seg_decoder`

## Requirements
- R1: After reset the flags read 0 and the five registers read 0x4840_0000, 0x4C48_0000, 0x504C_0000, 0x5450_0000 and 0x5854_0000. This is a 64 MB segment at the base unit 0x40, followed by 32 MB segments packed one after another.
- R2: A register reads as end field in bits 31:24, start field in bits 23:16 and zero in bits 15:0, whatever was written to bits 15:0. An accepted write is visible after the next rising clock edge.
- R3: On chip select 0 the start field always reads the base unit 0x40. A write with any other start is stored with the start replaced by 0x40, and it sets flag bit 0.
- R4: A write whose end field is at or below 0x40, or whose start field is above 0x60 (base plus span), is dropped and sets flag bit 1. A start field of exactly 0x60 is accepted.
- R5: A non-empty write (end > start) whose start field is not a multiple of end minus start is stored and sets flag bit 2.
- R6: A write is stored and sets flag bit 3 when, for some other chip select, new start < other end and new end > other start.
- R7: A write whose 32-bit data equals the current register content changes nothing and sets no flag.
- R8: The lookup reports a hit on the lowest-numbered chip select whose segment is non-empty and has start ≤ address < end (field × 8 MB). The reported offset is the address minus that start.
- R9: An address outside every non-empty segment gives hit 0, chip select 0 and offset 0.
- R10: Flags stay set until cleared. A flag is cleared by a cycle with the clear enable high and a 1 in that bit of the clear mask. When a flag is set and cleared in the same cycle, the set wins.
- R11: A write to a select value of 5 or above changes no register and no flag. A read of such a select returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Chip select of the register written |
| cfg_wdata | input | 32 | Write data |
| cfg_rsel | input | 3 | Chip select of the register read |
| cfg_rdata | output | 32 | Read data (combinational) |
| flag_clr_en | input | 1 | Flag clear strobe |
| flag_clr_mask | input | 4 | Ones clear the matching flag bits |
| err_flags | output | 4 | Sticky flags: 0 start fixed, 1 dropped, 2 misaligned, 3 overlap |
| look_addr | input | 32 | Bus address to decode |
| look_hit | output | 1 | Address falls in a segment |
| look_cs | output | 3 | Owning chip select |
| look_offset | output | 32 | Byte offset inside the segment |

## Verification
Several properties are checked on every cycle. The assertions confirm that the first device's start never leaves the base unit, and that no register moves without a write that selects it. They also confirm that dropped or identical writes leave the whole register file untouched, that flags fall only through the clear mask, and that a miss drives zero outputs. Other behaviours can only be shown by the bench's scenarios, because they depend on the values involved. These include the exact corrected and stored values, the window boundaries at base and base plus span, the modulo alignment result, and which of two overlapping segments the lookup picks.

// File: rtl/fseg_pkg.sv
// Shared types for the flash segment window decoder.
// Assumes 8-bit unit fields; flag bit positions are fixed here.
package fseg_pkg;
    localparam int UNIT_W    = 8;
    localparam int FLG_W     = 4;
    localparam int FLG_BASE  = 0;
    localparam int FLG_RANGE = 1;
    localparam int FLG_ALIGN = 2;
    localparam int FLG_OVLP  = 3;

    typedef struct packed {
        logic [UNIT_W-1:0] end_u;
        logic [UNIT_W-1:0] start_u;
    } seg_t;
endpackage

// File: rtl/fseg_wr_check.sv
// Validates a candidate segment write against the current register file.
// Purely combinational; the caller gates the results with its write strobe.
// Assumes sel may exceed NUM_CS-1, in which case the current value reads as 0.
module fseg_wr_check
    import fseg_pkg::*;
#(
    parameter int          NUM_CS     = 5,
    parameter int          CS_W       = 3,
    parameter logic [7:0]  BASE_UNIT  = 8'h40,
    parameter logic [7:0]  SPAN_UNITS = 8'h20
) (
    input  logic [CS_W-1:0]   sel,
    input  logic [31:0]       wdata,
    input  seg_t [NUM_CS-1:0] segs,
    output seg_t              cand,
    output logic              same,
    output logic              discard,
    output logic              fix_base,
    output logic              misalign,
    output logic              overlap
);
    localparam logic [8:0] LIMIT_U = {1'b0, BASE_UNIT} + {1'b0, SPAN_UNITS};

    seg_t       cur;
    logic [7:0] size_u;
    logic [7:0] div_u;

    // Select the current content of the addressed register.
    always_comb begin
        cur = '0;
        for (int i = 0; i < NUM_CS; i++) begin
            if (sel == CS_W'(i)) cur = segs[i];
        end
    end

    // Form the candidate and pin the first device's start.
    always_comb begin
        cand.end_u   = wdata[31:24];
        cand.start_u = wdata[23:16];
        fix_base     = (sel == '0) && (wdata[23:16] != BASE_UNIT);
        if (fix_base) cand.start_u = BASE_UNIT;
        same    = (wdata == {cur.end_u, cur.start_u, 16'h0000});
        discard = (cand.end_u <= BASE_UNIT) || ({1'b0, cand.start_u} > LIMIT_U);
    end

    // Size and modulo alignment of a non-empty candidate.
    always_comb begin
        size_u   = (cand.end_u > cand.start_u) ? (cand.end_u - cand.start_u) : 8'd0;
        div_u    = (size_u == 8'd0) ? 8'd1 : size_u;
        misalign = (size_u != 8'd0) && ((cand.start_u % div_u) != 8'd0);
    end

    // Intersection with any other chip select's segment.
    always_comb begin
        overlap = 1'b0;
        for (int i = 0; i < NUM_CS; i++) begin
            if ((sel != CS_W'(i)) &&
                (cand.start_u < segs[i].end_u) &&
                (cand.end_u > segs[i].start_u))
                overlap = 1'b1;
        end
    end
endmodule

// File: rtl/fseg_lookup.sv
// Decodes a bus address into the owning chip select and segment offset.
// Combinational; empty segments never match; the lowest index wins.
module fseg_lookup
    import fseg_pkg::*;
#(
    parameter int NUM_CS     = 5,
    parameter int CS_W       = 3,
    parameter int ADDR_W     = 32,
    parameter int UNIT_SHIFT = 23
) (
    input  logic [ADDR_W-1:0] addr,
    input  seg_t [NUM_CS-1:0] segs,
    output logic              hit,
    output logic [CS_W-1:0]   cs,
    output logic [ADDR_W-1:0] offset
);
    logic [ADDR_W-1:0] lo_a [NUM_CS];
    logic [ADDR_W-1:0] hi_a [NUM_CS];
    logic [NUM_CS-1:0] match;

    // Per-segment byte bounds and containment test.
    for (genvar g = 0; g < NUM_CS; g++) begin : g_seg
        assign lo_a[g]  = ADDR_W'(segs[g].start_u) << UNIT_SHIFT;
        assign hi_a[g]  = ADDR_W'(segs[g].end_u) << UNIT_SHIFT;
        assign match[g] = (segs[g].end_u > segs[g].start_u) &&
                          (addr >= lo_a[g]) && (addr < hi_a[g]);
    end

    // Priority pick: scan from the top so the lowest index is kept.
    always_comb begin
        hit    = 1'b0;
        cs     = '0;
        offset = '0;
        for (int i = NUM_CS - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit    = 1'b1;
                cs     = CS_W'(i);
                offset = addr - lo_a[i];
            end
        end
    end
endmodule

// File: rtl/flash_seg_decoder.sv
// Segment window register file with write validation and address lookup.
// Holds one start/end pair per chip select in 8 MB units, sticky error
// flags cleared by mask, and a combinational lookup port.
// Assumes synchronous active-low reset and a single write per cycle.
module flash_seg_decoder
    import fseg_pkg::*;
#(
    parameter int          NUM_CS      = 5,
    parameter int          ADDR_W      = 32,
    parameter int          UNIT_SHIFT  = 23,
    parameter logic [7:0]  BASE_UNIT   = 8'h40,
    parameter logic [7:0]  SPAN_UNITS  = 8'h20,
    parameter int          FIRST_UNITS = 8,
    parameter int          NEXT_UNITS  = 4,
    localparam int         CS_W        = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic [CS_W-1:0]   cfg_sel,
    input  logic [31:0]       cfg_wdata,
    input  logic [CS_W-1:0]   cfg_rsel,
    output logic [31:0]       cfg_rdata,
    input  logic              flag_clr_en,
    input  logic [FLG_W-1:0]  flag_clr_mask,
    output logic [FLG_W-1:0]  err_flags,
    input  logic [ADDR_W-1:0] look_addr,
    output logic              look_hit,
    output logic [CS_W-1:0]   look_cs,
    output logic [ADDR_W-1:0] look_offset
);
    seg_t [NUM_CS-1:0] seg_q;
    logic [FLG_W-1:0]  err_q;
    seg_t              cand;
    logic              same, discard, fix_base, misalign, overlap;
    logic              sel_ok, wr_live;
    logic [FLG_W-1:0]  set_vec, clr_vec;

    // Reset value of one chip select's segment.
    function automatic seg_t dflt_seg(int idx);
        seg_t s;
        if (idx == 0) begin
            s.start_u = BASE_UNIT;
            s.end_u   = BASE_UNIT + 8'(FIRST_UNITS);
        end else begin
            s.start_u = BASE_UNIT + 8'(FIRST_UNITS + (idx - 1) * NEXT_UNITS);
            s.end_u   = s.start_u + 8'(NEXT_UNITS);
        end
        return s;
    endfunction

    fseg_wr_check #(
        .NUM_CS(NUM_CS), .CS_W(CS_W), .BASE_UNIT(BASE_UNIT), .SPAN_UNITS(SPAN_UNITS)
    ) u_check (
        .sel(cfg_sel), .wdata(cfg_wdata), .segs(seg_q), .cand(cand),
        .same(same), .discard(discard), .fix_base(fix_base),
        .misalign(misalign), .overlap(overlap)
    );

    fseg_lookup #(
        .NUM_CS(NUM_CS), .CS_W(CS_W), .ADDR_W(ADDR_W), .UNIT_SHIFT(UNIT_SHIFT)
    ) u_look (
        .addr(look_addr), .segs(seg_q), .hit(look_hit), .cs(look_cs), .offset(look_offset)
    );

    // Qualify the write and build the flag set/clear vectors.
    always_comb begin
        sel_ok  = (32'(cfg_sel) < NUM_CS);
        wr_live = cfg_wr_en && sel_ok && !same;
        set_vec = '0;
        if (wr_live) begin
            set_vec[FLG_BASE]  = fix_base;
            set_vec[FLG_RANGE] = discard;
            set_vec[FLG_ALIGN] = misalign && !discard;
            set_vec[FLG_OVLP]  = overlap && !discard;
        end
        clr_vec = flag_clr_en ? flag_clr_mask : '0;
    end

    // Segment registers and sticky flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_CS; i++) seg_q[i] <= dflt_seg(i);
            err_q <= '0;
        end else begin
            for (int i = 0; i < NUM_CS; i++) begin
                if (wr_live && !discard && (cfg_sel == CS_W'(i))) seg_q[i] <= cand;
            end
            err_q <= (err_q & ~clr_vec) | set_vec;
        end
    end

    // Register read mux; unused low bits and bad selects read zero.
    always_comb begin
        cfg_rdata = '0;
        for (int i = 0; i < NUM_CS; i++) begin
            if (cfg_rsel == CS_W'(i))
                cfg_rdata = {seg_q[i].end_u, seg_q[i].start_u, 16'h0000};
        end
    end

    assign err_flags = err_q;

    // R3
    base_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seg_q[0].start_u == BASE_UNIT);

    // R4
    range_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_en && sel_ok && !same && discard) |=> $stable(seg_q));

    // R7
    same_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_en && sel_ok && same && !flag_clr_en) |=> ($stable(seg_q) && $stable(err_q)));

    // R10
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((err_q & ~clr_vec) != '0) |=> ((($past(err_q) & ~$past(clr_vec)) & ~err_q) == '0));

    // R9
    miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !look_hit |-> (look_cs == '0 && look_offset == '0));

    // R8
    hit_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
        look_hit |-> (32'(look_cs) < NUM_CS));

    for (genvar g = 0; g < NUM_CS; g++) begin : g_hold
        // R11
        reg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(cfg_wr_en && cfg_sel == CS_W'(g)) |=> $stable(seg_q[g]));
    end
endmodule

// File: tb/flash_seg_decoder_test.sv
// Directed bench: one task per scenario, each checking its own results.
module flash_seg_decoder_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [2:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic [2:0]  cfg_rsel = '0;
    logic [31:0] cfg_rdata;
    logic        flag_clr_en = 1'b0;
    logic [3:0]  flag_clr_mask = '0;
    logic [3:0]  err_flags;
    logic [31:0] look_addr = '0;
    logic        look_hit;
    logic [2:0]  look_cs;
    logic [31:0] look_offset;

    int n_cmp = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    flash_seg_decoder uut (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .cfg_rsel(cfg_rsel), .cfg_rdata(cfg_rdata),
        .flag_clr_en(flag_clr_en), .flag_clr_mask(flag_clr_mask), .err_flags(err_flags),
        .look_addr(look_addr), .look_hit(look_hit), .look_cs(look_cs), .look_offset(look_offset)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] sel, input logic [31:0] data,
                      input logic clr = 1'b0, input logic [3:0] mask = 4'h0);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_sel = sel; cfg_wdata = data;
        flag_clr_en = clr; flag_clr_mask = mask;
        @(negedge clk);
        cfg_wr_en = 1'b0; flag_clr_en = 1'b0; flag_clr_mask = '0;
        #1;
    endtask

    task automatic clr_flags(input logic [3:0] mask);
        @(negedge clk);
        flag_clr_en = 1'b1; flag_clr_mask = mask;
        @(negedge clk);
        flag_clr_en = 1'b0; flag_clr_mask = '0;
        #1;
    endtask

    task automatic chk_reg(input string tag, input logic [2:0] sel, input logic [31:0] exp);
        cfg_rsel = sel;
        #1;
        check(tag, cfg_rdata, exp);
    endtask

    task automatic chk_look(input string tag, input logic [31:0] addr, input logic hit,
                            input logic [2:0] cs, input logic [31:0] off);
        look_addr = addr;
        #1;
        check({tag, " hit"}, {31'h0, look_hit}, {31'h0, hit});
        check({tag, " cs"}, {29'h0, look_cs}, {29'h0, cs});
        check({tag, " off"}, look_offset, off);
    endtask

    task automatic chk_flags(input string tag, input logic [3:0] exp);
        #1;
        check(tag, {28'h0, err_flags}, {28'h0, exp});
    endtask

    task automatic t_reset;
        chk_reg("R1 cs0", 3'd0, 32'h4840_0000);
        chk_reg("R1 cs1", 3'd1, 32'h4C48_0000);
        chk_reg("R1 cs2", 3'd2, 32'h504C_0000);
        chk_reg("R1 cs3", 3'd3, 32'h5450_0000);
        chk_reg("R1 cs4", 3'd4, 32'h5854_0000);
        chk_flags("R1 flags", 4'h0);
    endtask

    task automatic t_lookup_default;
        chk_look("R8 cs0", 32'h2000_0010, 1'b1, 3'd0, 32'h0000_0010);
        chk_look("R8 cs1", 32'h2400_0004, 1'b1, 3'd1, 32'h0000_0004);
        chk_look("R8 cs4 top", 32'h2BFF_FFFF, 1'b1, 3'd4, 32'h01FF_FFFF);
        chk_look("R9 above", 32'h2C00_0000, 1'b0, 3'd0, 32'h0);
        chk_look("R9 below", 32'h1FFF_FFFF, 1'b0, 3'd0, 32'h0);
    endtask

    task automatic t_base_fix;
        wr(3'd0, 32'h4444_ABCD);
        chk_reg("R3 R2 cs0 corrected", 3'd0, 32'h4440_0000);
        chk_flags("R3 flag", 4'h1);
        chk_look("R9 gap", 32'h2300_0000, 1'b0, 3'd0, 32'h0);
        clr_flags(4'h1);
        chk_flags("R10 clear", 4'h0);
    endtask

    task automatic t_range;
        wr(3'd2, 32'h4030_0000);
        chk_reg("R4 end at base", 3'd2, 32'h504C_0000);
        chk_flags("R4 flag", 4'h2);
        wr(3'd3, 32'h7068_0000);
        chk_reg("R4 start beyond", 3'd3, 32'h5450_0000);
        clr_flags(4'hF);
        wr(3'd3, 32'h6460_0000);
        chk_reg("R4 start at limit", 3'd3, 32'h6460_0000);
        chk_flags("R4 limit no flag", 4'h0);
    endtask

    task automatic t_align;
        wr(3'd4, 32'h5B55_0000);
        chk_reg("R5 stored", 3'd4, 32'h5B55_0000);
        chk_flags("R5 flag", 4'h4);
        chk_look("R8 moved cs4", 32'h2A80_0100, 1'b1, 3'd4, 32'h0000_0100);
        clr_flags(4'h4);
    endtask

    task automatic t_overlap;
        wr(3'd1, 32'h5048_0000);
        chk_reg("R6 stored", 3'd1, 32'h5048_0000);
        chk_flags("R6 flag", 4'h8);
        chk_look("R8 priority", 32'h2680_0000, 1'b1, 3'd1, 32'h0280_0000);
        clr_flags(4'h8);
    endtask

    task automatic t_same;
        wr(3'd1, 32'h5048_0000);
        chk_flags("R7 no flag", 4'h0);
        chk_reg("R7 unchanged", 3'd1, 32'h5048_0000);
    endtask

    task automatic t_sticky;
        wr(3'd1, 32'h5448_0000, 1'b1, 4'h8);
        chk_flags("R10 set wins", 4'h8);
        clr_flags(4'h7);
        chk_flags("R10 other mask", 4'h8);
        @(negedge clk); @(negedge clk);
        chk_flags("R10 hold", 4'h8);
        clr_flags(4'h8);
        chk_flags("R10 cleared", 4'h0);
    endtask

    task automatic t_bad_sel;
        wr(3'd5, 32'h6060_0000);
        chk_reg("R11 read sel5", 3'd5, 32'h0);
        chk_reg("R11 read sel7", 3'd7, 32'h0);
        chk_reg("R11 cs4 kept", 3'd4, 32'h5B55_0000);
        chk_reg("R11 cs3 kept", 3'd3, 32'h6460_0000);
        chk_flags("R11 flags", 4'h0);
    endtask

    task automatic t_empty;
        wr(3'd4, 32'h5555_0000);
        chk_flags("R5 empty no flag", 4'h0);
        chk_look("R8 empty miss", 32'h2A80_0000, 1'b0, 3'd0, 32'h0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_lookup_default();
        t_base_fix();
        t_range();
        t_align();
        t_overlap();
        t_same();
        t_sticky();
        t_bad_sel();
        t_empty();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(8 * 20000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule